// File: doc/BRIEF.md
# Time-Save Snapshot Register Bank

This block keeps a bank of shadow registers next to the clock counters of a timekeeping unit. Each shadow byte mirrors one counter byte, such as seconds, minutes, hours, day of month or month. A single control register decides whether the bank follows the counters or keeps a frozen copy. Software clears the enable bit to take a consistent picture of all counter bytes at one instant. It can then read the bytes one at a time with no risk of a rollover between two reads. Setting the bit again makes the bank follow the counters once more.

A power-fail pulse from the supply monitor clears the enable bit by hardware. The bank then keeps the time at which power was lost, and software reads it back after the supply returns. The control register also holds six bits of general-purpose storage. The bank does not include the counters themselves or any analog detection.

The register port has a word address, a write strobe, write data and read data. Address 0 selects the control register. Addresses 1 to NUM_BYTES select the shadow bytes, and address k maps to counter byte k-1. The counter side presents both the current counter value and the value the counters load at the next edge, together with a load strobe. This lets the shadow match the counters on every edge.

Top module: `tsave_bank`

## Requirements
- R1: After reset, the control register reads 0x00 and every shadow byte reads 0x00.
- R2: The control register at address 0 reads back as {save_en at bit 7, constant 0 at bit 6, stored general bits at bits 5..0}. A write to address 0 stores bits 5..0 and bit 7. Bit 6 always reads 0, whatever value is written to it.
- R3: While save_en is 1 before a clock edge, each shadow byte takes, at that edge, the value its counter holds after the edge: cnt_next when cnt_load is high, otherwise cnt_now.
- R4: Writing 0 to bit 7 freezes the bank. The shadow bytes keep the values they captured on the write edge, and they stay unchanged while save_en is 0, even as the counters keep moving.
- R5: A one-cycle high on pwr_fail clears save_en at that edge. The shadow bytes keep the values captured on that edge. The general bits 5..0 are not changed.
- R6: If pwr_fail is high in the same cycle as a write to address 0, save_en ends at 0. Bits 5..0 still take the written value.
- R7: Writes to shadow addresses (1..NUM_BYTES), and writes to addresses above NUM_BYTES, are ignored. Neither the shadow bytes nor the control register change. Addresses above NUM_BYTES read 0x00.
- R8: Read data is available in the same cycle as the address, at all times, whether the bank is tracking or frozen (with the default READ_REG = 0).
- R9: Writing 1 to bit 7 restarts tracking. From the next edge on, the shadow bytes follow the counters again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the counters |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_now | input | NUM_BYTES*DATA_W | Current counter bytes; byte i sits at bits [i*DATA_W +: DATA_W] |
| cnt_next | input | NUM_BYTES*DATA_W | Values the counters load at the coming edge |
| cnt_load | input | 1 | High when the counters load cnt_next at the coming edge |
| pwr_fail | input | 1 | One-cycle power-fail pulse |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |

## Verification
The assertions check the following on every cycle:
- the edge-by-edge link between the shadow bytes and the counter inputs while tracking;
- that the shadow bytes stay fixed while frozen;
- that a power-fail pulse forces the enable low, including when it meets a control write;
- that writes to other addresses leave the enable alone;
- that bit 6 reads as zero.

Only the bench scenarios can show the rest. These cover the read-back of the general bits after a power fail and the value 0x00 at unused addresses. They also cover a frozen snapshot read back byte by byte while the counters run on, and the restart of tracking after a freeze. The bench checks each of these against a behavioural model, sampled on every clock.

// File: rtl/tsave_pkg.sv
package tsave_pkg;

   localparam int CTRL_ADDR = 0;

   // Number of register slots the bank occupies: the control word plus one per byte.
   function automatic int slot_count(input int nbytes);
      return nbytes + 1;
   endfunction

   // True when an address of addr_w bits can reach every slot.
   function automatic bit addr_fits(input int nbytes, input int addr_w);
      return (longint'(1) << addr_w) >= longint'(slot_count(nbytes));
   endfunction

endpackage

// File: rtl/tsave_ctrl.sv
module tsave_ctrl #(
   parameter int   DATA_W      = 8,
   parameter bit   SAVE_EN_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pwr_fail,
   output logic              save_en,
   output logic [DATA_W-1:0] ctrl_rd
);

   localparam int GP_W = DATA_W - 2;

   logic [GP_W-1:0] gp_q;
   logic            en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= SAVE_EN_RST;
         gp_q <= '0;
      end else begin
         if (wr_ctrl) begin
            gp_q <= wdata[GP_W-1:0];
            en_q <= wdata[DATA_W-1];
         end
         // the supply monitor overrides any software value of the enable
         if (pwr_fail) begin
            en_q <= 1'b0;
         end
      end
   end

   assign save_en = en_q;
   assign ctrl_rd = {en_q, 1'b0, gp_q};

endmodule

// File: rtl/tsave_shadow.sv
module tsave_shadow #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              track,
   input  logic              load,
   input  logic [DATA_W-1:0] now_val,
   input  logic [DATA_W-1:0] next_val,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (track) begin
         // take what the counter holds after this edge
         q <= load ? next_val : now_val;
      end
   end

endmodule

// File: rtl/tsave_rdmux.sv
module tsave_rdmux #(
   parameter int NUM_BYTES = 5,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter bit READ_REG  = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           ctrl_rd,
   input  logic [NUM_BYTES*DATA_W-1:0] shadow_flat,
   output logic [DATA_W-1:0]           rdata
);

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == ADDR_W'(tsave_pkg::CTRL_ADDR)) begin
         sel = ctrl_rd;
      end
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (addr == ADDR_W'(i + 1)) begin
            sel = shadow_flat[i*DATA_W +: DATA_W];
         end
      end
   end

   generate
      if (READ_REG) begin : g_reg_read
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_q <= '0;
            end else begin
               rd_q <= sel;
            end
         end
         assign rdata = rd_q;
      end else begin : g_comb_read
         assign rdata = sel;
      end
   endgenerate

endmodule

// File: rtl/tsave_bank.sv
module tsave_bank #(
   parameter int NUM_BYTES   = 5,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter bit READ_REG    = 1'b0,
   parameter bit SAVE_EN_RST = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BYTES*DATA_W-1:0] cnt_now,
   input  logic [NUM_BYTES*DATA_W-1:0] cnt_next,
   input  logic                        cnt_load,
   input  logic                        pwr_fail,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic                        reg_wr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata
);

   localparam int BANK_W = NUM_BYTES * DATA_W;

   generate
      if (NUM_BYTES < 1) begin : g_bad_bytes
         $error("tsave_bank: NUM_BYTES must be at least 1");
      end
      if (DATA_W < 3) begin : g_bad_width
         $error("tsave_bank: DATA_W must leave room for enable, zero bit and storage");
      end
      if (!tsave_pkg::addr_fits(NUM_BYTES, ADDR_W)) begin : g_bad_addr
         $error("tsave_bank: ADDR_W too narrow for the control word and all bytes");
      end
   endgenerate

   logic              save_en;
   logic [DATA_W-1:0] ctrl_rd;
   logic [BANK_W-1:0] shadow_flat;
   logic              wr_ctrl;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(tsave_pkg::CTRL_ADDR));

   tsave_ctrl #(
      .DATA_W      (DATA_W),
      .SAVE_EN_RST (SAVE_EN_RST)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wdata    (reg_wdata),
      .pwr_fail (pwr_fail),
      .save_en  (save_en),
      .ctrl_rd  (ctrl_rd)
   );

   generate
      for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
         tsave_shadow #(
            .DATA_W (DATA_W)
         ) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .track    (save_en),
            .load     (cnt_load),
            .now_val  (cnt_now[gi*DATA_W +: DATA_W]),
            .next_val (cnt_next[gi*DATA_W +: DATA_W]),
            .q        (shadow_flat[gi*DATA_W +: DATA_W])
         );
      end
   endgenerate

   tsave_rdmux #(
      .NUM_BYTES (NUM_BYTES),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .READ_REG  (READ_REG)
   ) u_rdmux (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (reg_addr),
      .ctrl_rd     (ctrl_rd),
      .shadow_flat (shadow_flat),
      .rdata       (reg_rdata)
   );

endmodule

// File: rtl/tsave_bank_chk.sv
module tsave_bank_chk #(
   parameter int NUM_BYTES = 5,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter bit READ_REG  = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_BYTES*DATA_W-1:0] cnt_now,
   input logic [NUM_BYTES*DATA_W-1:0] cnt_next,
   input logic                        cnt_load,
   input logic                        pwr_fail,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic                        reg_wr,
   input logic [DATA_W-1:0]           reg_wdata,
   input logic [DATA_W-1:0]           reg_rdata,
   input logic                        save_en,
   input logic [NUM_BYTES*DATA_W-1:0] shadow_flat
);

   logic ctrl_hit;
   assign ctrl_hit = reg_addr == ADDR_W'(0);

   assert_track_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      save_en |=> shadow_flat == $past(cnt_load ? cnt_next : cnt_now));

   assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !save_en |=> $stable(shadow_flat));

   assert_pf_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> !save_en);

   assert_pf_beats_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_fail && reg_wr && ctrl_hit) |=> !save_en);

   assert_other_wr_no_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !ctrl_hit && !pwr_fail) |=> save_en == $past(save_en));

   assert_reenable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ctrl_hit && reg_wdata[DATA_W-1] && !pwr_fail) |=> save_en);

   generate
      if (!READ_REG) begin : g_comb_checks
         assert_bit6_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_hit |-> reg_rdata[DATA_W-2] == 1'b0);
      end
   endgenerate

endmodule

bind tsave_bank tsave_bank_chk #(
   .NUM_BYTES (NUM_BYTES),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .READ_REG  (READ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt_now     (cnt_now),
   .cnt_next    (cnt_next),
   .cnt_load    (cnt_load),
   .pwr_fail    (pwr_fail),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .save_en     (save_en),
   .shadow_flat (shadow_flat)
);

// File: tb/tsave_bank_tb.sv
module tsave_bank_tb;

   localparam int NB = 5;
   localparam int DW = 8;
   localparam int AW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NB*DW-1:0]  cnt_now = '0;
   logic [NB*DW-1:0]  cnt_next = '0;
   logic              cnt_load = 1'b0;
   logic              pwr_fail = 1'b0;
   logic [AW-1:0]     reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic [DW-1:0]     reg_wdata = '0;
   logic [DW-1:0]     reg_rdata;

   int n_checks = 0;
   int n_fails  = 0;

   // behavioural reference state
   logic [DW-1:0] m_sh [NB];
   logic          m_en;
   logic [DW-3:0] m_gp;

   always #10 clk = ~clk;  // 50 MHz

   tsave_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_now   (cnt_now),
      .cnt_next  (cnt_next),
      .cnt_load  (cnt_load),
      .pwr_fail  (pwr_fail),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      if (a == 0) return {m_en, 1'b0, m_gp};
      if (int'(a) <= NB) return m_sh[int'(a) - 1];
      return '0;
   endfunction

   // One clock: apply inputs at the falling edge, compare the read port,
   // advance the model at the rising edge, then move the counters.
   task automatic step(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                       input logic pf, input logic ld, input string tag);
      logic [DW-1:0] exp;
      reg_addr  = a;
      reg_wr    = wr;
      reg_wdata = wd;
      pwr_fail  = pf;
      cnt_load  = ld;
      for (int i = 0; i < NB; i++) cnt_next[i*DW +: DW] = DW'($urandom);
      #2;
      exp = model_read(a);
      n_checks++;
      if (reg_rdata !== exp) begin
         n_fails++;
         $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, reg_rdata, exp);
      end
      @(posedge clk);
      for (int i = 0; i < NB; i++)
         if (m_en) m_sh[i] = ld ? cnt_next[i*DW +: DW] : cnt_now[i*DW +: DW];
      if (wr && a == 0) begin
         m_gp = wd[DW-3:0];
         m_en = wd[DW-1];
      end
      if (pf) m_en = 1'b0;
      @(negedge clk);
      if (ld) cnt_now = cnt_next;
   endtask

   task automatic read_all(input string tag);
      for (int a = 0; a < (1 << AW); a++) step(AW'(a), 1'b0, '0, 1'b0, 1'b1, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) m_sh[i] = '0;
      m_en = 1'b0;
      m_gp = '0;
      for (int i = 0; i < NB; i++) cnt_now[i*DW +: DW] = DW'(8'h10 + i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values at every address, counters idle
      for (int a = 0; a < (1 << AW); a++) step(AW'(a), 1'b0, '0, 1'b0, 1'b0, "R1");

      // R9/R3: enable tracking, then read while counters load and hold
      step(0, 1'b1, 8'h80 | 8'h2a, 1'b0, 1'b0, "R9");
      for (int k = 0; k < 20; k++) step(AW'(1 + k % NB), 1'b0, '0, 1'b0, k[0], "R3");
      read_all("R8");

      // R2: bit 6 written high reads 0, general bits read back
      step(0, 1'b1, 8'hff, 1'b0, 1'b1, "R2");
      step(0, 1'b0, '0, 1'b0, 1'b0, "R2");
      step(0, 1'b1, 8'hc0, 1'b0, 1'b1, "R2");
      step(0, 1'b0, '0, 1'b0, 1'b1, "R2");

      // R4: software freeze, counters keep moving
      step(0, 1'b1, 8'h15, 1'b0, 1'b1, "R4");
      for (int k = 0; k < 3; k++) read_all("R4");

      // R7: writes to shadow and unused addresses while frozen and while tracking
      for (int a = 1; a < (1 << AW); a++) step(AW'(a), 1'b1, 8'ha5, 1'b0, 1'b1, "R7");
      read_all("R7");
      step(0, 1'b1, 8'h80 | 8'h07, 1'b0, 1'b1, "R9");
      for (int a = 1; a < (1 << AW); a++) step(AW'(a), 1'b1, 8'h5a, 1'b0, 1'b1, "R7");
      read_all("R7");

      // R5: power fail while tracking, general bits kept, snapshot held
      step(3, 1'b0, '0, 1'b1, 1'b1, "R5");
      for (int k = 0; k < 2; k++) read_all("R5");

      // R6: power fail and enabling write in the same cycle
      step(0, 1'b1, 8'h80 | 8'h11, 1'b0, 1'b1, "R9");
      step(2, 1'b0, '0, 1'b0, 1'b1, "R3");
      step(0, 1'b1, 8'h80 | 8'h3c, 1'b1, 1'b1, "R6");
      for (int k = 0; k < 2; k++) read_all("R6");

      // R9: restart after the fail snapshot
      step(0, 1'b1, 8'h80, 1'b0, 1'b0, "R9");
      for (int k = 0; k < 10; k++) step(AW'(1 + k % NB), 1'b0, '0, 1'b0, ~k[0], "R9");
      read_all("R3");

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule